// File: doc/BRIEF.md
# Twelve-bit pixel word packer

This block sits in front of a 16-bit-wide memory write path. It takes a stream of 12-bit pixels and packs them into 16-bit words so that no bits are wasted. Four pixels make one 48-bit group, and each group leaves the block as three 16-bit words. Both sides use a valid/ready handshake.

A pixel marked as the end of a line closes the group early. The unused upper bits of that group are filled with zero. Only the words that hold pixel bits are sent, and the final word of the line carries a last flag. While a closed group is still being sent, the block refuses new pixels, so no pixel is lost when the output is held back.

Top module: `pix12_packer`

## Requirements
- R1: After the synchronous active-high reset, out_valid is 0 and in_ready is 1. The reset also empties any partly gathered group, so the next pixel becomes pixel 0 of a fresh group.
- R2: Pixel k of a group (k = 0 is the first accepted) occupies bits 12k+11 down to 12k of the 48-bit group. Bits above the last pixel are zero.
- R3: The words of a group are sent lowest first: word j carries group bits 16j+15 down to 16j. A full group of four pixels gives exactly three words.
- R4: A group closed by in_eol after n pixels (n = 1, 2, 3) gives ceil(12n/16) words, which is 1, 2 or 3. After those words no further word is offered.
- R5: out_last is 1 only on the final word of a group that was closed by in_eol. It is 0 on every other word, including all three words of a four-pixel group that has no end-of-line mark.
- R6: in_ready is 0 while any word of a closed group is still pending. A pixel offered during that time is not taken and does not appear in any later output.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_word and out_last hold their values.
- R8: The first word of a group is valid in the cycle right after the clock edge that accepts the pixel closing the group.
- R9: A fourth pixel that also carries in_eol gives three words, with out_last set on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be taken this cycle |
| in_pix | input | 12 | Pixel value |
| in_eol | input | 1 | Offered pixel is the last of its line |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_word | output | 16 | Packed memory word |
| out_last | output | 1 | Word is the last of a line |

## Verification
A closing pixel is accepted on a rising edge, and its first word is due at the falling edge that follows. The bench checks out_valid at exactly that falling edge. Each later word is due one cycle after the previous word is accepted, so the bench samples every word on a falling edge after out_valid is seen, with the handshake set up half a cycle earlier. Before accepting some words, the bench holds out_ready low for a few cycles and checks that the word stays unchanged. One falling edge after the expected final word of a group, the bench checks that out_valid is 0.

// File: rtl/pxpk_pkg.sv
`timescale 1ns/1ps
package pxpk_pkg;
  // words needed to carry n pixels of pw bits in words of ww bits
  function automatic int words_needed(input int n, input int pw, input int ww);
    return (n * pw + ww - 1) / ww;
  endfunction
endpackage

// File: rtl/pxpk_gather.sv
`timescale 1ns/1ps
module pxpk_gather #(
  parameter int PIX_W     = 12,
  parameter int GROUP_PIX = 4,
  localparam int GRP_W    = PIX_W * GROUP_PIX,
  localparam int PH_W     = (GROUP_PIX > 1) ? $clog2(GROUP_PIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [PIX_W-1:0] pix,
  input  logic             eol,
  output logic             fire,
  output logic [GRP_W-1:0] grp,
  output logic [PH_W:0]    npix
);
  logic [PIX_W-1:0] slot_q [GROUP_PIX];
  logic [PH_W-1:0]  phase_q;

  // the pixel being taken is merged in, so the group is ready on the same edge
  for (genvar k = 0; k < GROUP_PIX; k++) begin : g_merge
    assign grp[k*PIX_W +: PIX_W] = (phase_q == PH_W'(k)) ? pix : slot_q[k];
  end

  assign fire = take && (eol || (phase_q == PH_W'(GROUP_PIX - 1)));
  assign npix = {1'b0, phase_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      for (int k = 0; k < GROUP_PIX; k++) slot_q[k] <= '0;
    end else if (take) begin
      if (fire) begin
        phase_q <= '0;
        for (int k = 0; k < GROUP_PIX; k++) slot_q[k] <= '0;
      end else begin
        for (int k = 0; k < GROUP_PIX; k++)
          if (phase_q == PH_W'(k)) slot_q[k] <= pix;
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pxpk_drain.sv
`timescale 1ns/1ps
module pxpk_drain #(
  parameter int PIX_W     = 12,
  parameter int WORD_W    = 16,
  parameter int GROUP_PIX = 4,
  localparam int GRP_W    = PIX_W * GROUP_PIX,
  localparam int PH_W     = (GROUP_PIX > 1) ? $clog2(GROUP_PIX) : 1,
  localparam int MAX_WDS  = (GRP_W + WORD_W - 1) / WORD_W,
  localparam int SH_W     = MAX_WDS * WORD_W,
  localparam int CNT_W    = $clog2(MAX_WDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [GRP_W-1:0]  grp,
  input  logic [PH_W:0]     npix,
  input  logic              eol,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] left_q;
  logic             eol_q;
  logic [CNT_W-1:0] need;

  assign need      = CNT_W'(pxpk_pkg::words_needed(int'(npix), PIX_W, WORD_W));
  assign out_valid = (left_q != '0);
  assign out_word  = sh_q[WORD_W-1:0];
  assign out_last  = eol_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      eol_q  <= 1'b0;
    end else if (load) begin
      sh_q   <= SH_W'(grp);
      left_q <= need;
      eol_q  <= eol;
    end else if (out_valid && out_ready) begin
      sh_q   <= sh_q >> WORD_W;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/pix12_packer.sv
`timescale 1ns/1ps
module pix12_packer #(
  parameter int PIX_W     = 12,
  parameter int WORD_W    = 16,
  parameter int GROUP_PIX = 4,
  localparam int GRP_W    = PIX_W * GROUP_PIX,
  localparam int PH_W     = (GROUP_PIX > 1) ? $clog2(GROUP_PIX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  logic             take, fire;
  logic [GRP_W-1:0] grp;
  logic [PH_W:0]    npix;

  assign in_ready = !out_valid;
  assign take     = in_valid && in_ready;

  pxpk_gather #(.PIX_W(PIX_W), .GROUP_PIX(GROUP_PIX)) u_gather (
    .clk(clk), .rst(rst), .take(take), .pix(in_pix), .eol(in_eol),
    .fire(fire), .grp(grp), .npix(npix)
  );

  pxpk_drain #(.PIX_W(PIX_W), .WORD_W(WORD_W), .GROUP_PIX(GROUP_PIX)) u_drain (
    .clk(clk), .rst(rst), .load(fire), .grp(grp), .npix(npix), .eol(in_eol),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
    .out_last(out_last)
  );
endmodule

// File: rtl/pxpk_checker.sv
`timescale 1ns/1ps
module pxpk_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eol,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_last
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  a_r6_no_take_while_pending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  a_r5_last_only_with_word: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r8_word_after_close: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eol) |=> out_valid);
endmodule

bind pix12_packer pxpk_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_last(out_last)
);

// File: tb/sim_pix12_packer.sv
`timescale 1ns/1ps
module sim_pix12_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_pix = '0;
  logic        in_eol = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_word;
  logic        out_last;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pix12_packer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_eol(in_eol), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_last(out_last)
  );

  // entry: {pixel count, eol, p3, p2, p1, p0}, p0 in the low bits
  localparam logic [51:0] VEC [6] = '{
    {3'd4, 1'b0, 12'hABC, 12'h789, 12'h456, 12'h123},
    {3'd4, 1'b1, 12'h000, 12'hFFF, 12'h000, 12'hFFF},
    {3'd3, 1'b1, 12'h000, 12'h333, 12'h222, 12'h111},
    {3'd2, 1'b1, 12'h000, 12'h000, 12'h5A5, 12'hA5A},
    {3'd1, 1'b1, 12'h000, 12'h000, 12'h000, 12'h7FF},
    {3'd4, 1'b0, 12'h3C3, 12'hC3C, 12'h800, 12'h001}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_pix(input logic [11:0] p, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p; in_eol = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; in_eol = 1'b0;
  endtask

  task automatic send_group(input int n, input logic e, input logic [47:0] p);
    for (int k = 0; k < n; k++) send_pix(p[k*12 +: 12], e && (k == n - 1));
  endtask

  task automatic recv(input logic [15:0] ew, input logic el, input int stall);
    logic [15:0] held;
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    if (stall > 0) begin
      held = out_word;
      repeat (stall) @(negedge clk);
      check("R7 word held under stall", 48'(out_word), 48'(held));
      check("R6 in_ready low while pending", 48'(in_ready), 48'(0));
    end
    out_ready = 1'b1;
    check("R3 packed word", 48'(out_word), 48'(ew));
    check("R5 last flag", 48'(out_last), 48'(el));
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  // expected words come straight from the packing rule in R2/R3/R4
  task automatic drain_group(input int n, input logic e, input logic [47:0] p, input int stall);
    logic [47:0] g;
    int nw;
    g = '0;
    for (int k = 0; k < n; k++) g[k*12 +: 12] = p[k*12 +: 12];
    nw = (n * 12 + 15) / 16;
    for (int j = 0; j < nw; j++) recv(g[j*16 +: 16], e && (j == nw - 1), stall);
    @(negedge clk);
    check("R4 no extra word", 48'(out_valid), 48'(0));
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    fails++;
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", 48'(out_valid), 48'(0));
    check("R1 in_ready after reset", 48'(in_ready), 48'(1));

    // table walk: R2, R3, R4, R5, R8, R9
    for (int i = 0; i < 6; i++) begin
      send_group(int'(VEC[i][51:49]), VEC[i][48], VEC[i][47:0]);
      @(negedge clk);
      check("R8 first word due after closing pixel", 48'(out_valid), 48'(1));
      drain_group(int'(VEC[i][51:49]), VEC[i][48], VEC[i][47:0], i % 3);
    end

    // R1: reset in the middle of a group discards gathered pixels
    send_pix(12'h111, 1'b0);
    send_pix(12'h222, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send_pix(12'h0AB, 1'b1);
    drain_group(1, 1'b1, 48'h0AB, 0);

    // R6: pixel offered while words are pending is not taken
    send_group(4, 1'b0, 48'h400_300_200_100);
    @(negedge clk);
    in_valid = 1'b1; in_pix = 12'hEEE; in_eol = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 in_ready low during drain", 48'(in_ready), 48'(0));
    in_valid = 1'b0; in_eol = 1'b0;
    drain_group(4, 1'b0, 48'h400_300_200_100, 1);
    send_pix(12'h05A, 1'b1);
    drain_group(1, 1'b1, 48'h05A, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule